// File: doc/BRIEF.md
# PWM Beat and Phase Timebase

This block produces the shared timebase for a multi-channel pulse-width modulator. A programmable divider counts input clocks and raises a one-cycle beat strobe once every `div_i + 1` clocks. On each beat a 16-bit phase word advances by a step set by a logarithmic resolution input. The step is chosen so that one full PWM cycle always covers a power-of-two number of beats, `2^(res_i+1)`. The phase is a fraction of a PWM cycle in units of 2^-16. Only its top `res_i + 1` bits ever change.

Per-channel comparators read `phase_o` and compare it against their duty-cycle and phase-delay settings. They use `cycle_end_o` to realign once per PWM cycle. Clearing `cnt_en_i` holds both the divider and the phase at zero. Enabling again therefore restarts the timebase from a known point. Configuration inputs are assumed to be synchronous to `clk_i` already.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_ni` is low at a rising edge, the next cycle shows `phase_o` = 0 and a cleared divider count. With `cnt_en_i` low, `beat_o` and `cycle_end_o` are then 0.
- R2: While `cnt_en_i` is low, `beat_o` and `cycle_end_o` stay 0. From the cycle after the first edge with the enable low, `phase_o` reads 0.
- R3: With the enable held high and `div_i` = D constant, `beat_o` is high in the n-th enabled cycle exactly when n is a multiple of D+1. The first enabled cycle counts as n = 1.
- R4: At each rising edge where `beat_o` is high, `phase_o` increases by 2^(15-`res_i`), modulo 2^16. At an enabled edge without a beat, `phase_o` is unchanged.
- R5: `cycle_end_o` is high only together with `beat_o`, and only when that beat's addition carries out of 16 bits. With a constant configuration this happens every 2^(`res_i`+1) beats, so the PWM period is 2^(`res_i`+1)·(D+1) clocks.
- R6: Dropping the enable mid-run removes the beat in that same cycle and zeroes the phase at the next edge. When the enable rises again, the first beat comes D+1 cycles later.
- R7: If `div_i` is lowered to or below the current divider count, a beat is issued in that same cycle. The count then restarts from zero.
- R8: A change of `res_i` takes effect at the next beat. The phase is not reset, and the new step is applied to the existing phase word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cnt_en_i | input | 1 | Counter enable; low holds divider and phase at zero |
| div_i | input | 27 | Beat period minus one, in clocks |
| res_i | input | 4 | Log2 of beats per PWM cycle, minus one |
| phase_o | output | 16 | Current phase in units of 2^-16 cycle |
| beat_o | output | 1 | High in the cycle whose closing edge advances the phase |
| cycle_end_o | output | 1 | High on the beat where the phase wraps |

## Verification
The hardest situation to reach from the ports is the fine-resolution wrap. At the finest setting a PWM cycle spans 65,536 beats, so the wrap and its `cycle_end_o` strobe come only after a long run. The stimulus reaches it by using a divide-by-one beat and running one full PWM cycle at `res_i` = 15. Every phase value on the way is predicted arithmetically from the cycle index.

Two other cases are also driven on purpose. One lowers `div_i` below a count that is already running. The other switches `res_i` in the middle of a cycle.

// File: rtl/pwm_timebase_pkg.sv
// Package: shared widths and the strobe bundle used inside the PWM timebase.
// Assumes: consumers override module parameters rather than these defaults.
package pwm_timebase_pkg;
    localparam int unsigned DEF_DIV_W   = 27;
    localparam int unsigned DEF_PHASE_W = 16;
    localparam int unsigned DEF_RES_W   = 4;

    typedef struct packed {
        logic beat;
        logic cycle_end;
    } tb_strobe_t;
endpackage

// File: rtl/pwm_beat_div.sv
// Module: beat divider. Counts clocks and flags the last clock of every
// (div_i+1)-clock beat period. Assumes div_i is synchronous to clk_i.
// A count at or above the limit ends the period, so lowering div_i
// mid-count cannot overrun the counter.
module pwm_beat_div #(
    parameter int unsigned DIV_W = 27
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             beat_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_limit;

    // Terminal detect: end of the current beat period.
    always_comb begin
        at_limit = (cnt_q >= div_i);
        beat_o   = en_i && at_limit;
    end

    // Clock counter: cleared when disabled or at the end of a period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!en_i || at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_step_decode.sv
// Module: step decoder. Turns the logarithmic resolution code into the
// phase increment 2^(PHASE_W-1-res). Codes past PHASE_W-1 are clamped;
// the clamp is built only when the code width can express such values.
module pwm_step_decode #(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned RES_W   = 4
) (
    input  logic [RES_W-1:0]   res_i,
    output logic [PHASE_W-1:0] step_o
);
    localparam int unsigned MAX_RES = PHASE_W - 1;

    logic [RES_W-1:0] res_eff;

    generate
        if ((2 ** RES_W) > PHASE_W) begin : g_clamp
            // Clamp: limit the code to the finest usable resolution.
            always_comb begin
                if (int'(res_i) > MAX_RES) res_eff = RES_W'(MAX_RES);
                else                       res_eff = res_i;
            end
        end else begin : g_pass
            // Pass: every code is already in range.
            always_comb res_eff = res_i;
        end
    endgenerate

    // Shift: one at bit (MAX_RES - res_eff).
    always_comb begin
        step_o = PHASE_W'(1) << (MAX_RES - int'(res_eff));
    end
endmodule

// File: rtl/pwm_phase_acc.sv
// Module: phase accumulator. Adds the step on each beat, wrapping modulo
// 2^PHASE_W, and flags the beat whose addition carries out. Held at zero
// while disabled.
module pwm_phase_acc #(
    parameter int unsigned PHASE_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               beat_i,
    input  logic [PHASE_W-1:0] step_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W:0]   sum;

    // Adder: next phase plus carry out.
    always_comb begin
        sum    = {1'b0, phase_q} + {1'b0, step_i};
        wrap_o = beat_i && sum[PHASE_W];
    end

    // Phase register: cleared when disabled, advanced on a beat.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (!en_i) begin
            phase_q <= '0;
        end else if (beat_i) begin
            phase_q <= sum[PHASE_W-1:0];
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/pwm_timebase.sv
// Module: PWM timebase top. Joins the beat divider, step decoder and phase
// accumulator into one shared timebase for all channels. Assumes all
// inputs are synchronous to clk_i; reset is synchronous, active low.
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned DIV_W   = DEF_DIV_W,
    parameter int unsigned PHASE_W = DEF_PHASE_W,
    parameter int unsigned RES_W   = DEF_RES_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cnt_en_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [RES_W-1:0]   res_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               beat_o,
    output logic               cycle_end_o
);
    tb_strobe_t         strb;
    logic [PHASE_W-1:0] step;

    pwm_beat_div #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cnt_en_i),
        .div_i  (div_i),
        .beat_o (strb.beat)
    );

    pwm_step_decode #(.PHASE_W(PHASE_W), .RES_W(RES_W)) u_step (
        .res_i  (res_i),
        .step_o (step)
    );

    pwm_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (cnt_en_i),
        .beat_i  (strb.beat),
        .step_i  (step),
        .phase_o (phase_o),
        .wrap_o  (strb.cycle_end)
    );

    // Output mapping: strobe bundle to ports.
    always_comb begin
        beat_o      = strb.beat;
        cycle_end_o = strb.cycle_end;
    end
endmodule

// File: rtl/pwm_timebase_chk.sv
// Checker: temporal properties of the PWM timebase, bound to every instance.
module pwm_timebase_chk #(
    parameter int unsigned DIV_W   = 27,
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned RES_W   = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cnt_en_i,
    input logic [DIV_W-1:0]   div_i,
    input logic [RES_W-1:0]   res_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               beat_o,
    input logic               cycle_end_o
);
    // Expected step from the resolution code (clamped to the finest slice).
    function automatic logic [PHASE_W-1:0] exp_step(input logic [RES_W-1:0] r);
        int unsigned rr;
        rr = (int'(r) > PHASE_W - 1) ? PHASE_W - 1 : int'(r);
        return PHASE_W'(1) << (PHASE_W - 1 - rr);
    endfunction

    // R1: reset clears the phase.
    a_r1_reset_phase: assert property (@(posedge clk_i)
        !rst_ni |=> phase_o == '0);

    // R2 / R6: a disabled edge leaves the phase at zero.
    a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_en_i |=> phase_o == '0);

    // R3: with a nonzero divider, beats are never back to back.
    a_r3_no_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_o && div_i != '0) |=> (!beat_o || div_i == '0));

    // R4: a beat advances the phase by the decoded step.
    a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_o |=> phase_o == PHASE_W'($past(phase_o) + exp_step($past(res_i))));

    // R4: an enabled edge without a beat holds the phase.
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_en_i && !beat_o) |=> $stable(phase_o));

    // R5: the end-of-cycle strobe only rides on a beat.
    a_r5_end_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cycle_end_o |-> beat_o);

    // R5: after a cycle end the phase has wrapped below its old value.
    a_r5_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cycle_end_o |=> phase_o < $past(phase_o));
endmodule

bind pwm_timebase pwm_timebase_chk #(
    .DIV_W(DIV_W), .PHASE_W(PHASE_W), .RES_W(RES_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_en_i    (cnt_en_i),
    .div_i       (div_i),
    .res_i       (res_i),
    .phase_o     (phase_o),
    .beat_o      (beat_o),
    .cycle_end_o (cycle_end_o)
);

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps divider and resolution settings, predicting every output
// arithmetically from the enabled-cycle index.
module pwm_timebase_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [26:0] div = 27'h8000;
    logic [3:0]  res = 4'd7;
    logic [15:0] phase;
    logic        beat;
    logic        cend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_timebase dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cnt_en_i    (en),
        .div_i       (div),
        .res_i       (res),
        .phase_o     (phase),
        .beat_o      (beat),
        .cycle_end_o (cend)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Disable for one edge, then check the idle state (R2).
    task automatic go_idle();
        tick(); en = 1'b0;
        #1 chk(beat == 1'b0, "R2 beat while disabled", beat, 0);
        tick();
        #1 chk(phase == 16'd0, "R2 phase after disable", phase, 0);
        chk(cend == 1'b0, "R2 cycle_end while disabled", cend, 0);
    endtask

    // Enabled run of ncyc cycles with constant D and R (R3, R4, R5).
    task automatic sweep(input int d, input int r, input int ncyc);
        longint stp;
        stp = longint'(1) << (15 - r);
        go_idle();
        for (int n = 1; n <= ncyc; n++) begin
            longint done_b, ephase;
            bit eb, ec;
            tick(); en = 1'b1; div = 27'(d); res = 4'(r);
            #1;
            done_b = (n - 1) / (d + 1);
            ephase = (done_b * stp) % 65536;
            eb = (n % (d + 1)) == 0;
            ec = eb && (((n / (d + 1)) % (longint'(1) << (r + 1))) == 0);
            chk(phase == 16'(ephase), "R4 phase", phase, ephase);
            chk(beat == eb, "R3 beat", beat, eb);
            chk(cend == ec, "R5 cycle_end", cend, ec);
        end
    endtask

    initial begin
        repeat (3) tick();
        #1 chk(phase == 16'd0 && beat == 1'b0 && cend == 1'b0, "R1 reset state",
               {phase, beat, cend}, 0);
        tick(); rst_n = 1'b1;
        #1 chk(phase == 16'd0 && beat == 1'b0, "R1 after release", phase, 0);

        for (int d = 0; d < 4; d++)
            for (int r = 0; r < 7; r++)
                sweep(d, r, 2 * (1 << (r + 1)) * (d + 1) + 2);

        // Finest resolution: one full 65536-beat cycle at divide-by-one.
        sweep(0, 15, 65536 + 3);

        // R6: drop enable mid-run, then restart.
        sweep(1, 2, 9);
        tick(); en = 1'b0;
        #1 chk(beat == 1'b0, "R6 beat gone on disable", beat, 0);
        tick();
        #1 chk(phase == 16'd0, "R6 phase zeroed", phase, 0);
        tick(); en = 1'b1;
        #1 chk(beat == 1'b0, "R6 no beat in first cycle", beat, 0);
        tick();
        #1 chk(beat == 1'b1, "R6 first beat after D+1", beat, 1);

        // R7: lower the divider below a running count.
        go_idle();
        for (int n = 1; n <= 6; n++) begin
            tick(); en = 1'b1; div = 27'd10; res = 4'd3;
            #1 chk(beat == 1'b0, "R7 no early beat", beat, 0);
        end
        tick(); div = 27'd2;
        #1 chk(beat == 1'b1, "R7 beat on lowered limit", beat, 1);
        tick();
        #1 chk(beat == 1'b0, "R7 count restarted", beat, 0);
        chk(phase == 16'd4096, "R7 phase advanced once", phase, 4096);
        tick();
        tick();
        #1 chk(beat == 1'b1, "R7 next beat after 3", beat, 1);

        // R8: change resolution mid-cycle.
        go_idle();
        tick(); en = 1'b1; div = 27'd0; res = 4'd0;
        #1 chk(phase == 16'd0 && beat == 1'b1, "R8 start", phase, 0);
        tick(); res = 4'd1;
        #1 chk(phase == 16'd32768, "R8 old step applied", phase, 32768);
        chk(cend == 1'b0, "R8 no wrap yet", cend, 0);
        tick();
        #1 chk(phase == 16'd49152, "R8 new step applied", phase, 49152);
        chk(cend == 1'b1, "R8 wrap on carry", cend, 1);
        tick();
        #1 chk(phase == 16'd0, "R8 wrapped to zero", phase, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule